// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. Fetch, decode, operand read, ALU work, data access, write-back and the choice of the next program counter all happen inside one clock period.

It runs a small integer subset: five register-to-register operations, one word load, one word store, one conditional branch on equality and one absolute jump. Fields sit at the usual positions of a 32-bit three-operand encoding: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], funct [5:0], immediate [15:0], jump target [25:0].

The core has two independent memory ports. The fetch port drives the program counter out and takes the instruction word back. The data port drives an address, store data and a write enable, and takes load data back. Both ports are plain and carry no handshake. The core consumes one instruction per cycle and cannot stall, so the memories behind it must answer combinationally in the same cycle. A store is committed by the memory on the rising edge that ends the cycle in which the write enable is high.

Top module: `sc_core`

## Requirements
- R1: An active-high `rst` clears the program counter to 0x00000000 at once, without waiting for a clock edge. While `rst` is high the counter stays at zero.
- R2: Any instruction that is not a taken branch and not a jump advances the program counter by 4 on the next rising edge.
- R3: beq (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next counter value is PC + 4 + (sign-extended imm16 shifted left by 2). When they differ, the next value is PC + 4. Negative offsets branch backwards.
- R4: j (opcode 0x02) sets the next counter value to {bits [31:28] of PC + 4, target26, 2'b00}. The top nibble therefore comes from the incremented counter, not from the current one.
- R5: The register file holds 32 words. Its two read ports are combinational. A write lands on the rising edge, and the next cycle reads the new value.
- R6: Register 0 always reads as zero, even right after an instruction that names it as the destination.
- R7: Opcode 0x00 with shift amount 0 selects an ALU operation by funct: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. Set-less-than compares as signed and writes 1 or 0. The result goes to rd.
- R8: lw (0x23) and sw (0x2B) address memory at rs + the sign-extended imm16. lw writes the load data to rt. sw drives rt onto `dmem_wdata` with `dmem_we` high for that single cycle, and for no other instruction.
- R9: Any other opcode, an unlisted funct, or a register-type word with a nonzero shift amount writes no register, does not drive `dmem_we` high, and advances the counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Asynchronous active-high reset of the program counter |
| imem_addr | output | 32 | Program counter, the byte address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of a load or store (ALU result) |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | High for one cycle while a store executes |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
Each program-counter effect is due at the first rising edge after its instruction is presented. The bench therefore waits one edge per instruction and reads `imem_addr` on the following falling edge. A register write also lands on that edge, but it can only be seen when a later store copies it out. A stored word is in the bench memory at the edge that ends the store's cycle, so memory contents are inspected after every instruction in the program, including its closing self-jump, has retired. `dmem_we` is sampled mid-cycle while the instruction under test is being fetched, and the asynchronous reset is checked one nanosecond after it rises, with no clock edge in between.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;    // write back into the register file
    logic    dst_rd;    // destination is rd (else rt)
    logic    src_imm;   // second ALU operand from the extended immediate
    logic    wb_load;   // write-back value comes from load data
    logic    mem_we;    // store
    logic    branch;    // conditional branch on zero
    logic    jump;      // absolute jump
    logic    ext_zero;  // zero-extend the immediate instead of sign-extend
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);

  // Register-type operation chosen by funct; valid only when shamt is zero.
  logic    fn_known;
  alu_op_e fn_op;

  always_comb begin
    fn_known = 1'b1;
    fn_op    = ALU_ADD;
    unique case (funct)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_known = 1'b0;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        if (fn_known && (shamt == 5'd0)) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = fn_op;
        end
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.wb_load = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.src_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: begin
        ctrl.reg_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 32,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [RD_PORTS-1:0][IDX_W-1:0] rd_idx,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [ENTRIES];

  // Entry 0 is never written; its reads are forced to zero below.
  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx != '0)) store[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = (rd_idx[p] == '0) ? '0 : store[rd_idx[p]];
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              is_zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_SLT: res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/sc_imm_ext.sv
module sc_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] ext
);

  assign ext = {{(DATA_W-IMM_W){imm[IMM_W-1] & ~zero_ext}}, imm};

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int IMM_W    = 16,
  localparam int TGT_W    = 26
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [DATA_W-1:0] imem_data,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [DATA_W-1:0] dmem_rdata
);

  // ---------------- instruction fields ----------------
  logic [5:0]       f_op, f_fn;
  logic [4:0]       f_sh;
  logic [IDX_W-1:0] f_rs, f_rt, f_rd;
  logic [IMM_W-1:0] f_imm;
  logic [TGT_W-1:0] f_tgt;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_sh  = imem_data[10:6];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[15:0];
  assign f_tgt = imem_data[25:0];

  // ---------------- control ----------------
  ctrl_t ctrl;

  sc_decoder u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .shamt  (f_sh),
    .ctrl   (ctrl)
  );

  // ---------------- register file ----------------
  logic [1:0][IDX_W-1:0]  rf_ridx;
  logic [1:0][DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0]      rs_val, rt_val, wb_val;
  logic [IDX_W-1:0]       wr_idx;

  assign rf_ridx[0] = f_rs;
  assign rf_ridx[1] = f_rt;
  assign rs_val     = rf_rdata[0];
  assign rt_val     = rf_rdata[1];
  assign wr_idx     = ctrl.dst_rd ? f_rd : f_rt;

  sc_regfile #(
    .DATA_W   (DATA_W),
    .ENTRIES  (REG_COUNT),
    .RD_PORTS (2)
  ) u_rf (
    .clk     (clk),
    .wr_en   (ctrl.reg_we),
    .wr_idx  (wr_idx),
    .wr_data (wb_val),
    .rd_idx  (rf_ridx),
    .rd_data (rf_rdata)
  );

  // ---------------- execute ----------------
  logic [DATA_W-1:0] imm_val, alu_b, alu_y;
  logic              alu_z;

  sc_imm_ext #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_ext (
    .imm      (f_imm),
    .zero_ext (ctrl.ext_zero),
    .ext      (imm_val)
  );

  assign alu_b = ctrl.src_imm ? imm_val : rt_val;

  sc_alu #(.DATA_W(DATA_W)) u_alu (
    .opa     (rs_val),
    .opb     (alu_b),
    .op      (ctrl.alu_op),
    .res     (alu_y),
    .is_zero (alu_z)
  );

  assign wb_val = ctrl.wb_load ? dmem_rdata : alu_y;

  // ---------------- data port ----------------
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;

  // ---------------- next PC ----------------
  logic [DATA_W-1:0] pc_q, pc_inc, pc_br, pc_jmp, pc_nxt;
  logic              br_take;

  assign pc_inc  = pc_q + DATA_W'(4);
  assign pc_br   = pc_inc + {imm_val[DATA_W-3:0], 2'b00};
  assign pc_jmp  = {pc_inc[DATA_W-1:DATA_W-4], f_tgt, 2'b00};
  assign br_take = ctrl.branch & alu_z;

  always_comb begin
    if (ctrl.jump)   pc_nxt = pc_jmp;
    else if (br_take) pc_nxt = pc_br;
    else              pc_nxt = pc_inc;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign imem_addr = pc_q;

  // ---------------- assertions ----------------
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !br_take) |=> (imem_addr == $past(imem_addr) + 32'd4)); // R2

  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (rst)
    (br_take && !ctrl.jump) |=>
      (imem_addr == $past(imem_addr) + 32'd4 +
        {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00})); // R3

  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (imem_addr[27:0] == {$past(imem_data[25:0]), 2'b00})); // R4

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (imem_addr[31:28] == $past(imem_addr[31:28] + {3'b000, &imem_addr[27:2]}))); // R4

  AST_RF_READBACK: assert property (@(posedge clk) disable iff (rst)
    (ctrl.reg_we && (wr_idx != '0)) |=>
      ((f_rs != $past(wr_idx)) || (rs_val == $past(wb_val)))); // R5

  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_data[31:26] == OPC_STORE)); // R8

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !ctrl.reg_we); // R9

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sc_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // ---------------- encoders ----------------
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [4:0] sh, logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0000_0000;
      dmem[i] <= 32'hDEAD_BEEF;
    end
  endtask

  task automatic start();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    clear_all();
    imem[0] = enc_j(26'd0);
    start();
    chk("R1", imem_addr, 32'h0, "pc after reset release");
    for (int i = 1; i < 6; i++) imem[i] = 32'h0;
    imem[0] = 32'h0;
    step(3);
    chk("R2", imem_addr, 32'hC, "pc after three plain steps");
    @(posedge clk);
    #5 rst = 1'b1;
    #1 chk("R1", imem_addr, 32'h0, "asynchronous clear between edges");
    @(negedge clk);
    chk("R1", imem_addr, 32'h0, "pc held while reset high");
  endtask

  task automatic t_alu_mem();
    clear_all();
    dmem[0] <= 32'd5;
    dmem[1] <= 32'd12;
    dmem[2] <= 32'hFFFF_FFFD;
    dmem[3] <= 32'h0000_0080;
    imem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    imem[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
    imem[3]  = enc_i(6'h23, 5'd0, 5'd10, 16'd12);
    imem[4]  = enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h20);
    imem[5]  = enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h22);
    imem[6]  = enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h24);
    imem[7]  = enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'h25);
    imem[8]  = enc_r(5'd3, 5'd1, 5'd8, 5'd0, 6'h2A);
    imem[9]  = enc_r(5'd1, 5'd3, 5'd9, 5'd0, 6'h2A);
    imem[10] = enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'h20);
    imem[11] = enc_i(6'h2B, 5'd0, 5'd4, 16'h40);
    imem[12] = enc_i(6'h2B, 5'd0, 5'd5, 16'h44);
    imem[13] = enc_i(6'h2B, 5'd0, 5'd6, 16'h48);
    imem[14] = enc_i(6'h2B, 5'd0, 5'd7, 16'h4C);
    imem[15] = enc_i(6'h2B, 5'd0, 5'd8, 16'h50);
    imem[16] = enc_i(6'h2B, 5'd0, 5'd9, 16'h54);
    imem[17] = enc_i(6'h2B, 5'd0, 5'd0, 16'h58);
    imem[18] = enc_i(6'h2B, 5'd10, 5'd1, 16'hFFFC);
    imem[19] = enc_j(26'd19);
    start();
    step(22);
    chk("R7", dmem[16], 32'd17, "add");
    chk("R7", dmem[17], 32'hFFFF_FFF9, "sub");
    chk("R7", dmem[18], 32'd4, "and");
    chk("R7", dmem[19], 32'd13, "or");
    chk("R7", dmem[20], 32'd1, "slt negative < positive");
    chk("R7", dmem[21], 32'd0, "slt positive < negative");
    chk("R6", dmem[22], 32'd0, "register 0 after write");
    chk("R8", dmem[31], 32'd5, "store with negative offset");
    chk("R5", imem_addr, 32'h4C, "halted on self jump");
  endtask

  task automatic t_branch();
    logic [31:0] exp_pc [8] = '{32'h4, 32'h8, 32'h14, 32'h18, 32'h1C, 32'h14, 32'h18, 32'h1C};
    clear_all();
    dmem[0] <= 32'd5;
    imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd0);
    imem[2] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
    imem[3] = enc_i(6'h2B, 5'd0, 5'd1, 16'h40);
    imem[4] = enc_i(6'h2B, 5'd0, 5'd1, 16'h44);
    imem[5] = enc_i(6'h04, 5'd1, 5'd0, 16'd5);
    imem[6] = enc_i(6'h2B, 5'd0, 5'd2, 16'h48);
    imem[7] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFD);
    start();
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R3", imem_addr, exp_pc[i], $sformatf("pc trace step %0d", i));
    end
    chk("R3", dmem[16], 32'hDEAD_BEEF, "skipped store 1");
    chk("R3", dmem[17], 32'hDEAD_BEEF, "skipped store 2");
    chk("R8", dmem[18], 32'd5, "store after untaken branch");
  endtask

  task automatic t_jump();
    logic [31:0] exp_pc [5] = '{32'h40, 32'h0FFF_FFFC, 32'h1000_0008, 32'h1000_0000, 32'h1000_0040};
    clear_all();
    imem[0]  = enc_j(26'h10);
    imem[16] = enc_j(26'h3FF_FFFF);
    imem[63] = enc_j(26'd2);
    imem[2]  = enc_j(26'd0);
    start();
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R4", imem_addr, exp_pc[i], $sformatf("jump trace step %0d", i));
    end
  endtask

  task automatic t_illegal();
    clear_all();
    dmem[0] <= 32'd5;
    imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1] = enc_r(5'd0, 5'd0, 5'd1, 5'd0, 6'h26);
    imem[2] = enc_r(5'd0, 5'd0, 5'd1, 5'd1, 6'h20);
    imem[3] = 32'hFC00_0040;
    imem[4] = enc_i(6'h2B, 5'd0, 5'd1, 16'h40);
    imem[5] = enc_j(26'd5);
    start();
    step(1);
    for (int i = 1; i < 4; i++) begin
      chk("R9", {31'd0, dmem_we}, 32'd0, $sformatf("no store for illegal word %0d", i));
      step(1);
      chk("R9", imem_addr, 32'(4 * (i + 1)), $sformatf("pc steps past illegal word %0d", i));
    end
    chk("R8", {31'd0, dmem_we}, 32'd1, "write enable during sw");
    step(3);
    chk("R9", dmem[16], 32'd5, "register kept across illegal words");
  endtask

  // ---------------- run ----------------
  initial begin
    t_reset();
    t_alu_mem();
    t_branch();
    t_jump();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule